// File: doc/BRIEF.md
# Bubble-Tolerant Delay-Line Edge Encoder

The block turns the registered snapshot of a long tapped delay line into a fine-time bin number. Tap 0 is the tap nearest the line entry. A hit that has travelled through the line leaves a run of ones in the low taps followed by zeros. Supply disturbance during the capture can flip single taps, which produces bubbles. A plain encoder would take the first one-to-zero boundary, but this block accepts a boundary only when the bits around it have the shape of a real propagating edge. Any other toggle is treated as noise.

The snapshot is split into 64-tap segments. Each segment finds its lowest qualifying position. A registered merge stage then picks the lowest segment that found one. The result is labelled by a small verdict state machine with three states. V_IDLE means no snapshot was offered. V_HIT means an edge was found, and the block raises a valid strobe with the bin and the tag of the capture cycle. V_MISS means a snapshot was offered but no position qualified, and the block pulses a reject and advances a reject counter. Each cycle the machine moves from any state to one of the three. It goes to V_IDLE when the stage holds no snapshot, to V_HIT when a position qualified, and to V_MISS otherwise.

Top module: `tdl_bubble_encoder`

## Requirements
- R1: Position i (tap index, tap 0 nearest the line entry) is a candidate only if taps i-4..i-1 all read 1 and taps i..i+3 all read 0. Positions closer than 4 taps to either end of the vector never qualify, so a reported bin lies in 4..TAPS-4.
- R2: When several positions qualify, the lowest index is reported, including when the pattern spans two 64-tap segments.
- R3: A bubble does not create a hit and does not displace a genuine edge. A bubble is a single flipped tap, or a run of fewer than 4 zeros inside the ones region.
- R4: An offered snapshot in which no position qualifies gives reject_o high for one cycle and hit_vld_o low.
- R5: rej_cnt_o increases by exactly one in each cycle in which reject_o is high, holds otherwise, and wraps from all ones to zero.
- R6: A snapshot sampled at clock edge E has its verdict on the outputs after edge E+2, which is three register stages. One snapshot per cycle is accepted without gaps.
- R7: tag_o carries the tag sampled with the snapshot whenever hit_vld_o or reject_o is high.
- R8: A cycle with snap_vld_i low produces neither hit_vld_o nor reject_o, and it leaves rej_cnt_o unchanged.
- R9: While rst_n is low, hit_vld_o, reject_o and rej_cnt_o are zero. A snapshot still in flight at reset produces no result.
- R10: hit_vld_o and reject_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snap_vld_i | input | 1 | A snapshot is offered this cycle |
| snap_i | input | TAPS (576) | Tap snapshot, bit 0 nearest the line entry |
| tag_i | input | TAG_W (8) | Capture-cycle tag |
| hit_vld_o | output | 1 | A genuine edge was found |
| reject_o | output | 1 | The snapshot held no qualifying edge |
| bin_o | output | BIN_W (10) | Fine-time bin of the edge |
| tag_o | output | TAG_W (8) | Tag of the judged snapshot |
| rej_cnt_o | output | CNT_W (16) | Count of rejected snapshots |

## Verification
Noise rejection and edge location act on the same snapshot in the same cycle. The bench builds vectors that hold a bubble or a short zero run next to a real edge, and vectors in which an earlier four-plus-four pattern beats a later edge. It judges the reported bin against the lowest position that meets the pattern rule, and it checks that a near-edge bubble turns the verdict into a reject. Rejects and hits also arrive in back-to-back cycles. The reject counter is compared against a running count kept by the bench, and it is driven through its wrap.

// File: rtl/tdl_enc_pkg.sv
package tdl_enc_pkg;
    typedef enum logic [1:0] {
        V_IDLE = 2'd0,
        V_HIT  = 2'd1,
        V_MISS = 2'd2
    } verdict_e;
endpackage

// File: rtl/tdl_seg_scan.sv
module tdl_seg_scan #(
    parameter int SEG_W = 64,
    localparam int POS_W = $clog2(SEG_W)
) (
    input  logic [SEG_W-1:0] mask_i,
    output logic             hit_o,
    output logic [POS_W-1:0] pos_o
);
    always_comb begin
        hit_o = |mask_i;
        pos_o = '0;
        for (int k = SEG_W - 1; k >= 0; k--) begin
            if (mask_i[k]) pos_o = POS_W'(k);
        end
    end
endmodule

// File: rtl/tdl_seg_merge.sv
module tdl_seg_merge #(
    parameter int NSEG  = 9,
    parameter int SEG_W = 64,
    parameter int BIN_W = 10,
    localparam int POS_W = $clog2(SEG_W)
) (
    input  logic [NSEG-1:0]            seg_hit_i,
    input  logic [NSEG-1:0][POS_W-1:0] seg_pos_i,
    output logic                       found_o,
    output logic [BIN_W-1:0]           bin_o
);
    always_comb begin
        found_o = |seg_hit_i;
        bin_o   = '0;
        for (int s = NSEG - 1; s >= 0; s--) begin
            if (seg_hit_i[s]) bin_o = BIN_W'(s * SEG_W) + BIN_W'(seg_pos_i[s]);
        end
    end
endmodule

// File: rtl/tdl_bubble_encoder.sv
module tdl_bubble_encoder
    import tdl_enc_pkg::*;
#(
    parameter int TAPS  = 576,
    parameter int SEG_W = 64,
    parameter int GUARD = 4,
    parameter int BIN_W = 10,
    parameter int TAG_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_vld_i,
    input  logic [TAPS-1:0]  snap_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             hit_vld_o,
    output logic             reject_o,
    output logic [BIN_W-1:0] bin_o,
    output logic [TAG_W-1:0] tag_o,
    output logic [CNT_W-1:0] rej_cnt_o
);
    localparam int NSEG  = TAPS / SEG_W;
    localparam int POS_W = $clog2(SEG_W);

    // stage 0: captured snapshot
    logic [TAPS-1:0]  cap_q;
    logic             cap_vld_q;
    logic [TAG_W-1:0] cap_tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= '0;
            cap_vld_q <= 1'b0;
            cap_tag_q <= '0;
        end else begin
            cap_q     <= snap_i;
            cap_vld_q <= snap_vld_i;
            cap_tag_q <= tag_i;
        end
    end

    // pattern qualification: GUARD ones below, GUARD zeros at and above
    logic [TAPS-1:0] qual;
    for (genvar i = 0; i < TAPS; i++) begin : g_qual
        if (i >= GUARD && i + GUARD <= TAPS) begin : g_in
            assign qual[i] = (&cap_q[i-1 -: GUARD]) & ~(|cap_q[i +: GUARD]);
        end else begin : g_edge
            assign qual[i] = 1'b0;
        end
    end

    // stage 1: per-segment lowest candidate
    logic [NSEG-1:0]            seg_hit_d, seg_hit_q;
    logic [NSEG-1:0][POS_W-1:0] seg_pos_d, seg_pos_q;
    logic                       s1_vld_q;
    logic [TAG_W-1:0]           s1_tag_q;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        tdl_seg_scan #(.SEG_W(SEG_W)) u_scan (
            .mask_i (qual[s*SEG_W +: SEG_W]),
            .hit_o  (seg_hit_d[s]),
            .pos_o  (seg_pos_d[s])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_hit_q <= '0;
            seg_pos_q <= '0;
            s1_vld_q  <= 1'b0;
            s1_tag_q  <= '0;
        end else begin
            seg_hit_q <= seg_hit_d;
            seg_pos_q <= seg_pos_d;
            s1_vld_q  <= cap_vld_q;
            s1_tag_q  <= cap_tag_q;
        end
    end

    // stage 2: merge and verdict
    logic             found;
    logic [BIN_W-1:0] found_bin;

    tdl_seg_merge #(.NSEG(NSEG), .SEG_W(SEG_W), .BIN_W(BIN_W)) u_merge (
        .seg_hit_i (seg_hit_q),
        .seg_pos_i (seg_pos_q),
        .found_o   (found),
        .bin_o     (found_bin)
    );

    verdict_e         state_q, state_d;
    logic [BIN_W-1:0] bin_q;
    logic [TAG_W-1:0] tag_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (!s1_vld_q)  state_d = V_IDLE;
        else if (found) state_d = V_HIT;
        else            state_d = V_MISS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= V_IDLE;
            bin_q   <= '0;
            tag_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == V_HIT)  bin_q <= found_bin;
            if (state_d != V_IDLE) tag_q <= s1_tag_q;
            if (state_d == V_MISS) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        hit_vld_o = 1'b0;
        reject_o  = 1'b0;
        unique case (state_q)
            V_IDLE: ;
            V_HIT:  hit_vld_o = 1'b1;
            V_MISS: reject_o  = 1'b1;
            default: ;
        endcase
    end

    assign bin_o     = bin_q;
    assign tag_o     = tag_q;
    assign rej_cnt_o = cnt_q;

    // cycles since reset, saturating, for history-dependent checks
    logic [1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              since_q <= '0;
        else if (since_q != 2'd3) since_q <= since_q + 1'b1;
    end

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd3) |-> ((hit_vld_o || reject_o) == $past(snap_vld_i, 3)));

    assert_bin_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld_o |-> (int'(bin_o) >= GUARD && int'(bin_o) <= TAPS - GUARD));

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != 2'd0 && reject_o) |-> (rej_cnt_o == $past(rej_cnt_o) + 1'b1));

    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != 2'd0 && !reject_o) |-> $stable(rej_cnt_o));
endmodule

// File: tb/tb_tdl_bubble_encoder.sv
module tb_tdl_bubble_encoder;
    localparam int TAPS = 576;
    localparam int N    = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             snap_vld_i = 1'b0;
    logic [TAPS-1:0]  snap_i = '0;
    logic [7:0]       tag_i = '0;
    logic             hit_vld_o, reject_o;
    logic [9:0]       bin_o;
    logic [7:0]       tag_o;
    logic [15:0]      rej_cnt_o;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    always #10 clk = ~clk;

    tdl_bubble_encoder dut (
        .clk(clk), .rst_n(rst_n), .snap_vld_i(snap_vld_i), .snap_i(snap_i),
        .tag_i(tag_i), .hit_vld_o(hit_vld_o), .reject_o(reject_o),
        .bin_o(bin_o), .tag_o(tag_o), .rej_cnt_o(rej_cnt_o)
    );

    // vld, edge, zero-run start, zero-run length, forced one, exp hit, exp bin
    typedef struct packed {
        int vld; int e; int za; int zl; int oa; int ehit; int ebin;
    } vec_t;

    localparam vec_t VEC [N] = '{
        '{1, 100, 0,   0, -1,  1, 100},
        '{1, 4,   0,   0, -1,  1, 4},
        '{1, 572, 0,   0, -1,  1, 572},
        '{1, 573, 0,   0, -1,  0, 0},
        '{1, 3,   0,   0, -1,  0, 0},
        '{1, 200, 50,  1, -1,  1, 200},
        '{1, 200, 0,   0, 300, 1, 200},
        '{1, 200, 0,   0, 210, 1, 200},
        '{1, 200, 198, 1, -1,  0, 0},
        '{1, 200, 190, 2, -1,  1, 200},
        '{1, 64,  0,   0, -1,  1, 64},
        '{1, 63,  0,   0, -1,  1, 63},
        '{1, 0,   0,   0, -1,  0, 0},
        '{1, 576, 0,   0, -1,  0, 0},
        '{1, 300, 100, 4, -1,  1, 100},
        '{1, 300, 100, 3, -1,  1, 300},
        '{1, 300, 62,  4, -1,  1, 62},
        '{0, 100, 0,   0, -1,  0, 0},
        '{1, 0,   0,   0, 10,  0, 0},
        '{1, 128, 0,   0, -1,  1, 128}
    };

    function automatic logic [TAPS-1:0] mk(input vec_t v);
        logic [TAPS-1:0] r;
        for (int i = 0; i < TAPS; i++) r[i] = (i < v.e);
        for (int k = 0; k < v.zl; k++) r[v.za + k] = 1'b0;
        if (v.oa >= 0) r[v.oa] = 1'b1;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic judge(input vec_t v, input int j);
        bit erej;
        erej = (v.vld != 0) && (v.ehit == 0);
        if (erej) exp_cnt++;
        // R1 R2 R3: hit and bin; R4 R8: reject; R10: exclusive
        chk(hit_vld_o == (v.ehit != 0), "R3 hit", int'(hit_vld_o), v.ehit);
        chk(reject_o == erej, "R4 reject", int'(reject_o), int'(erej));
        chk(!(hit_vld_o && reject_o), "R10 exclusive", int'(hit_vld_o), 0);
        if (v.ehit != 0) chk(int'(bin_o) == v.ebin, "R2 bin", int'(bin_o), v.ebin);
        if (v.vld != 0) chk(int'(tag_o) == (j & 255), "R7 tag", int'(tag_o), j & 255);
        chk(int'(rej_cnt_o) == (exp_cnt & 16'hFFFF), "R5 count", int'(rej_cnt_o), exp_cnt);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!hit_vld_o && !reject_o, "R9 reset outputs", int'(hit_vld_o | reject_o), 0);
        chk(rej_cnt_o == 0, "R9 reset count", int'(rej_cnt_o), 0);
        rst_n = 1'b1;

        // streamed table, R6: result three negedges after driving
        for (int j = 0; j < N + 3; j++) begin
            @(negedge clk);
            if (j >= 3) judge(VEC[j-3], j - 3);
            if (j < N) begin
                snap_vld_i = (VEC[j].vld != 0);
                snap_i     = mk(VEC[j]);
                tag_i      = 8'(j);
            end else begin
                snap_vld_i = 1'b0;
            end
        end

        // R8: idle cycles leave everything quiet
        repeat (4) begin
            @(negedge clk);
            chk(!hit_vld_o && !reject_o, "R8 idle", int'(hit_vld_o | reject_o), 0);
            chk(int'(rej_cnt_o) == exp_cnt, "R8 count hold", int'(rej_cnt_o), exp_cnt);
        end

        // R6: single hit appears exactly after the third register stage
        snap_vld_i = 1'b1;
        snap_i     = mk('{1, 150, 0, 0, -1, 1, 150});
        tag_i      = 8'hA5;
        @(negedge clk);
        snap_vld_i = 1'b0;
        @(negedge clk);
        chk(!hit_vld_o, "R6 not early", int'(hit_vld_o), 0);
        @(negedge clk);
        chk(hit_vld_o && bin_o == 150, "R6 on time", int'(bin_o), 150);
        chk(tag_o == 8'hA5, "R7 single tag", int'(tag_o), 165);
        @(negedge clk);
        chk(!hit_vld_o, "R6 one cycle", int'(hit_vld_o), 0);

        // R9: reset while a snapshot is in flight
        snap_vld_i = 1'b1;
        snap_i     = '0;
        @(negedge clk);
        snap_vld_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(rej_cnt_o == 0, "R9 count cleared", int'(rej_cnt_o), 0);
        rst_n = 1'b1;
        exp_cnt = 0;
        repeat (4) begin
            @(negedge clk);
            chk(!hit_vld_o && !reject_o, "R9 flush", int'(hit_vld_o | reject_o), 0);
        end

        // R5: wrap of the reject counter
        snap_vld_i = 1'b1;
        snap_i     = '0;
        repeat (65535) @(negedge clk);
        snap_vld_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(rej_cnt_o == 16'hFFFF, "R5 full", int'(rej_cnt_o), 65535);
        snap_vld_i = 1'b1;
        @(negedge clk);
        snap_vld_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(reject_o && rej_cnt_o == 0, "R5 wrap", int'(rej_cnt_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule